// File: doc/BRIEF.md
# Mixed-Page-Size Translation Cache

This block is a small fully associative cache of address translations. Each slot holds one page: a page-aligned virtual base, a page-size code (4 KB, 2 MB or 4 MB), a page-aligned physical base and six attribute bits. Pages of all three sizes share one array. A slot matches by a range compare against its own size. The cache does no masked tag compare at a fixed size.

A page walker fills the cache through the fill port. The core asks for translations on the lookup port, and the answer appears one clock after the request. Two invalidate commands manage the contents. One frees every slot. The other frees only the slots whose global attribute is clear. Victims are chosen by true least-recently-used order. The order is held as a per-slot recency rank, where 0 means most recent. Empty slots form a free pool, and the cache draws on that pool before it evicts anything. The number of slots is a parameter.

Top module: `vtlb_top`

## Requirements
- R1: After reset every slot is free: `lu_hit`, `lu_pa` and `lu_attr` are 0, and any lookup misses.
- R2: A slot hits when its virtual base is less than or equal to `lu_va` and `lu_va` is below base plus page size. Size code 0 is 4 KB, 1 is 2 MB, 2 is 4 MB, and 3 is treated as 4 KB. A page that ends at the top of the address space still hits on its last byte.
- R3: On a hit, `lu_pa` is the slot's physical base ORed with (`lu_va` AND (page size − 1)), and `lu_attr` is the slot's attribute bits. Both are registered and appear on the clock after `lu_req`. On a miss, or with no request, `lu_hit`, `lu_pa` and `lu_attr` are 0.
- R4: A fill stores its virtual and physical addresses with the offset bits for its page size cleared.
- R5: A fill takes a free slot whenever one exists, so no valid page is evicted while the pool is non-empty. When no slot is free, the fill evicts the least recently used valid slot.
- R6: A newly filled slot becomes the most recently used.
- R7: A hitting lookup with `lu_promote`=1 makes the hit slot the most recently used. With `lu_promote`=0 the recency order is left unchanged.
- R8: Fills do no duplicate or overlap check. When several slots match, the most recently used one supplies the result.
- R9: `inv_all` returns every slot to the free pool.
- R10: `inv_nonglobal` frees only the slots whose attribute bit 4 (global) is clear. Surviving global slots keep their relative recency order. The other attribute bits are bit 0 writable, bit 1 user, bit 2 no-execute, bit 3 uncacheable and bit 5 page-attribute index.
- R11: When a fill and an invalidate arrive in the same cycle, the invalidate is applied first and the new page survives it.
- R12: A lookup in the same cycle as a fill or an invalidate is answered from the contents before that cycle's update. Its promotion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_req | input | 1 | Lookup request |
| lu_va | input | VA_W | Lookup virtual address |
| lu_promote | input | 1 | Promote a hit slot to most recently used |
| lu_hit | output | 1 | Registered hit |
| lu_pa | output | PA_W | Registered physical address |
| lu_attr | output | 6 | Registered attribute bits of the hit slot |
| fill_req | input | 1 | Insert a page |
| fill_va | input | VA_W | Virtual address of the page being inserted |
| fill_pa | input | PA_W | Physical address of the page being inserted |
| fill_size | input | 2 | Page-size code |
| fill_attr | input | 6 | Attribute bits of the page |
| inv_all | input | 1 | Free every slot |
| inv_nonglobal | input | 1 | Free slots whose global bit is clear |

## Verification
The bench sweeps each size code against the addresses one below the page, the first byte, the last byte and one past the page. A design that compared tags at a fixed size, or clipped the offset with the wrong mask, would hit or miss at the wrong edge or return a physical address with stray bits. Eviction order is driven with promoting and non-promoting hits. A design that promoted on every hit, or ignored promotion, would evict a page that should have stayed resident. Overlapping pages, selective invalidation followed by refills, and invalidates that coincide with fills or lookups expose a design that picks the wrong match, scrambles the surviving order, loses the new page, or answers from updated contents.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_4M  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_PROMOTE = 2'd1,
        UPD_INSERT  = 2'd2
    } upd_op_e;

    localparam int ATTR_W   = 6;
    localparam int ATTR_WR  = 0;
    localparam int ATTR_USR = 1;
    localparam int ATTR_NX  = 2;
    localparam int ATTR_UC  = 3;
    localparam int ATTR_GLB = 4;
    localparam int ATTR_PAT = 5;

    // number of offset bits for a page-size code
    function automatic int unsigned pg_shift(input pg_size_e code);
        unique case (code)
            PG_2M:   return 21;
            PG_4M:   return 22;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int N    = 4,
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0]         va,
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][VA_W-1:0]  vbase_arr,
    input  logic [N-1:0][1:0]       size_arr,
    output logic [N-1:0]            hit_vec
);
    localparam logic [VA_W-1:0] ONE = VA_W'(1);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [VA_W-1:0] span_m1;
        logic [VA_W:0]   lo;
        logic [VA_W:0]   hi;
        logic [VA_W:0]   probe;

        assign span_m1 = (ONE << pg_shift(pg_size_e'(size_arr[i]))) - ONE;
        // one extra bit so a page ending at the top of the space does not wrap
        assign lo      = {1'b0, vbase_arr[i]};
        assign hi      = lo + {1'b0, span_m1} + {{VA_W{1'b0}}, 1'b1};
        assign probe   = {1'b0, va};
        assign hit_vec[i] = valid_vec[i] && (probe >= lo) && (probe < hi);
    end

endmodule

// File: rtl/vtlb_store.sv
module vtlb_store
    import vtlb_pkg::*;
#(
    parameter int N    = 4,
    parameter int VA_W = 32,
    parameter int PA_W = 32,
    parameter int IW   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IW-1:0]                slot,
    input  logic [VA_W-1:0]              va_in,
    input  logic [PA_W-1:0]              pa_in,
    input  logic [1:0]                   size_in,
    input  logic [ATTR_W-1:0]            attr_in,
    output logic [N-1:0][VA_W-1:0]       vbase_arr,
    output logic [N-1:0][PA_W-1:0]       pbase_arr,
    output logic [N-1:0][1:0]            size_arr,
    output logic [N-1:0][ATTR_W-1:0]     attr_arr
);
    localparam logic [VA_W-1:0] ONE_V = VA_W'(1);
    localparam logic [PA_W-1:0] ONE_P = PA_W'(1);

    logic [VA_W-1:0] vmask;
    logic [PA_W-1:0] pmask;

    always_comb begin
        vmask = (ONE_V << pg_shift(pg_size_e'(size_in))) - ONE_V;
        pmask = (ONE_P << pg_shift(pg_size_e'(size_in))) - ONE_P;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbase_arr <= '0;
            pbase_arr <= '0;
            size_arr  <= '0;
            attr_arr  <= '0;
        end else if (we) begin
            vbase_arr[slot] <= va_in & ~vmask;
            pbase_arr[slot] <= pa_in & ~pmask;
            size_arr[slot]  <= size_in;
            attr_arr[slot]  <= attr_in;
        end
    end

endmodule

// File: rtl/vtlb_recency.sv
module vtlb_recency
    import vtlb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_all,
    input  logic                   flush_ng,
    input  logic [N-1:0]           glob_vec,
    input  upd_op_e                op,
    input  logic [IW-1:0]          promote_idx,
    output logic [N-1:0]           valid_vec,
    output logic [N-1:0][IW-1:0]   rank_arr,
    output logic [IW-1:0]          ins_slot
);
    localparam logic [IW-1:0] LRU_RANK = IW'(N - 1);

    logic [N-1:0]          valid_q, valid_n, v1;
    logic [N-1:0][IW-1:0]  rank_q, rank_n, r1;
    logic [IW-1:0]         slot_free, slot_lru, cnt;
    logic                  have_free;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rank_q  <= '0;
        end else begin
            valid_q <= valid_n;
            rank_q  <= rank_n;
        end
    end

    // next state: invalidate first, then fill or promotion
    always_comb begin
        v1 = valid_q;
        r1 = rank_q;
        if (flush_all) begin
            v1 = '0;
        end else if (flush_ng) begin
            for (int i = 0; i < N; i++) v1[i] = valid_q[i] & glob_vec[i];
            // compact survivors, keeping their relative order
            for (int i = 0; i < N; i++) begin
                cnt = '0;
                for (int j = 0; j < N; j++)
                    if (v1[j] && rank_q[j] < rank_q[i]) cnt = cnt + IW'(1);
                r1[i] = cnt;
            end
        end

        slot_free = '0;
        have_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!v1[i]) begin
                slot_free = IW'(i);
                have_free = 1'b1;
            end
        end
        slot_lru = '0;
        for (int i = 0; i < N; i++)
            if (v1[i] && r1[i] == LRU_RANK) slot_lru = IW'(i);
        ins_slot = have_free ? slot_free : slot_lru;

        valid_n = v1;
        rank_n  = r1;
        unique case (op)
            UPD_INSERT: begin
                for (int i = 0; i < N; i++) begin
                    if (IW'(i) == ins_slot) begin
                        valid_n[i] = 1'b1;
                        rank_n[i]  = '0;
                    end else if (v1[i]) begin
                        rank_n[i]  = r1[i] + IW'(1);
                    end
                end
            end
            UPD_PROMOTE: begin
                for (int i = 0; i < N; i++)
                    if (valid_q[i] && rank_q[i] < rank_q[promote_idx])
                        rank_n[i] = rank_q[i] + IW'(1);
                rank_n[promote_idx] = '0;
            end
            default: ;
        endcase
    end

    assign valid_vec = valid_q;
    assign rank_arr  = rank_q;

    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i != j && valid_q[i] && valid_q[j] && rank_q[i] == rank_q[j]) dup = 1'b1;
    end

    AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        !dup); // R5
    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (op == UPD_INSERT && !flush_all && !flush_ng && !(&valid_q))
        |=> $countones(valid_q) == $past($countones(valid_q)) + 1); // R5
    AST_FILL_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        op == UPD_INSERT |=> valid_q[$past(ins_slot)] && rank_q[$past(ins_slot)] == '0); // R6
    AST_PROMOTE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
        (op == UPD_PROMOTE && !flush_all && !flush_ng)
        |=> rank_q[$past(promote_idx)] == '0); // R7
    AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (op == UPD_HOLD && !flush_all && !flush_ng)
        |=> (valid_q == $past(valid_q) && rank_q == $past(rank_q))); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && op != UPD_INSERT) |=> valid_q == '0); // R9
    AST_FLUSH_KEEP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ng && !flush_all && op != UPD_INSERT)
        |=> valid_q == $past(valid_q & glob_vec)); // R10

endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
    import vtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int VA_W        = 32,
    parameter int PA_W        = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lu_req,
    input  logic [VA_W-1:0]    lu_va,
    input  logic               lu_promote,
    output logic               lu_hit,
    output logic [PA_W-1:0]    lu_pa,
    output logic [5:0]         lu_attr,
    input  logic               fill_req,
    input  logic [VA_W-1:0]    fill_va,
    input  logic [PA_W-1:0]    fill_pa,
    input  logic [1:0]         fill_size,
    input  logic [5:0]         fill_attr,
    input  logic               inv_all,
    input  logic               inv_nonglobal
);
    localparam int N  = NUM_ENTRIES;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [VA_W-1:0] ONE = VA_W'(1);

    logic [N-1:0]                valid_vec, hit_vec, glob_vec;
    logic [N-1:0][IW-1:0]        rank_arr;
    logic [N-1:0][VA_W-1:0]      vbase_arr;
    logic [N-1:0][PA_W-1:0]      pbase_arr;
    logic [N-1:0][1:0]           size_arr;
    logic [N-1:0][ATTR_W-1:0]    attr_arr;
    logic [IW-1:0]               ins_slot, win_idx, best_rank;
    logic                        found;
    logic [VA_W-1:0]             off_va;
    logic [PA_W-1:0]             pa_c;
    upd_op_e                     op;

    for (genvar i = 0; i < N; i++) begin : g_glob
        assign glob_vec[i] = attr_arr[i][ATTR_GLB];
    end

    vtlb_match #(.N(N), .VA_W(VA_W)) u_match (
        .va        (lu_va),
        .valid_vec (valid_vec),
        .vbase_arr (vbase_arr),
        .size_arr  (size_arr),
        .hit_vec   (hit_vec)
    );

    vtlb_store #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .IW(IW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (fill_req),
        .slot      (ins_slot),
        .va_in     (fill_va),
        .pa_in     (fill_pa),
        .size_in   (fill_size),
        .attr_in   (fill_attr),
        .vbase_arr (vbase_arr),
        .pbase_arr (pbase_arr),
        .size_arr  (size_arr),
        .attr_arr  (attr_arr)
    );

    vtlb_recency #(.N(N), .IW(IW)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_all   (inv_all),
        .flush_ng    (inv_nonglobal),
        .glob_vec    (glob_vec),
        .op          (op),
        .promote_idx (win_idx),
        .valid_vec   (valid_vec),
        .rank_arr    (rank_arr),
        .ins_slot    (ins_slot)
    );

    // most recently used matching slot wins
    always_comb begin
        found     = 1'b0;
        win_idx   = '0;
        best_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i] && (!found || rank_arr[i] < best_rank)) begin
                found     = 1'b1;
                best_rank = rank_arr[i];
                win_idx   = IW'(i);
            end
        end
        off_va = lu_va & ((ONE << pg_shift(pg_size_e'(size_arr[win_idx]))) - ONE);
        pa_c   = pbase_arr[win_idx] | PA_W'(off_va);
    end

    // recency command: fill outranks promotion; invalidates cancel promotion
    always_comb begin
        if (fill_req)
            op = UPD_INSERT;
        else if (lu_req && lu_promote && found && !inv_all && !inv_nonglobal)
            op = UPD_PROMOTE;
        else
            op = UPD_HOLD;
    end

    // registered lookup outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lu_hit  <= 1'b0;
            lu_pa   <= '0;
            lu_attr <= '0;
        end else if (lu_req && found) begin
            lu_hit  <= 1'b1;
            lu_pa   <= pa_c;
            lu_attr <= attr_arr[win_idx];
        end else begin
            lu_hit  <= 1'b0;
            lu_pa   <= '0;
            lu_attr <= '0;
        end
    end

    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lu_hit |-> $past(lu_req)); // R3
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lu_hit |-> (lu_pa == '0 && lu_attr == '0)); // R3
    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec == '0) |=> !lu_hit); // R1

endmodule

// File: tb/tb_vtlb_top.sv
`timescale 1ns/1ps
module tb_vtlb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lu_req = 1'b0, lu_promote = 1'b0;
    logic [31:0] lu_va = '0;
    logic        lu_hit;
    logic [31:0] lu_pa;
    logic [5:0]  lu_attr;
    logic        fill_req = 1'b0;
    logic [31:0] fill_va = '0, fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic [5:0]  fill_attr = '0;
    logic        inv_all = 1'b0, inv_nonglobal = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vtlb_top #(.NUM_ENTRIES(4), .VA_W(32), .PA_W(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .lu_req(lu_req), .lu_va(lu_va), .lu_promote(lu_promote),
        .lu_hit(lu_hit), .lu_pa(lu_pa), .lu_attr(lu_attr),
        .fill_req(fill_req), .fill_va(fill_va), .fill_pa(fill_pa),
        .fill_size(fill_size), .fill_attr(fill_attr),
        .inv_all(inv_all), .inv_nonglobal(inv_nonglobal)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock: inputs were set at a negedge, results sampled at the next negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        lu_req = 1'b0; lu_promote = 1'b0; fill_req = 1'b0;
        inv_all = 1'b0; inv_nonglobal = 1'b0;
    endtask

    task automatic set_fill(input logic [31:0] va, input logic [31:0] pa,
                            input logic [1:0] sz, input logic [5:0] at);
        fill_req = 1'b1; fill_va = va; fill_pa = pa; fill_size = sz; fill_attr = at;
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa,
                        input logic [1:0] sz, input logic [5:0] at);
        set_fill(va, pa, sz, at);
        tick();
    endtask

    task automatic flush_all();
        inv_all = 1'b1;
        tick();
    endtask

    task automatic expect_hit(input logic [31:0] va, input bit prom, input logic [31:0] epa,
                              input logic [5:0] eat, input string req);
        lu_req = 1'b1; lu_va = va; lu_promote = prom;
        tick();
        chk(lu_hit == 1'b1, req, 64'(lu_hit), 64'd1);
        chk(lu_pa == epa, req, 64'(lu_pa), 64'(epa));
        chk(lu_attr == eat, req, 64'(lu_attr), 64'(eat));
    endtask

    task automatic expect_miss(input logic [31:0] va, input string req);
        lu_req = 1'b1; lu_va = va; lu_promote = 1'b0;
        tick();
        chk(lu_hit == 1'b0, req, 64'(lu_hit), 64'd0);
        chk(lu_pa == 32'd0, req, 64'(lu_pa), 64'd0);
    endtask

    function automatic logic [31:0] smask(input int s);
        return (s == 1) ? 32'h001F_FFFF : (s == 2) ? 32'h003F_FFFF : 32'h0000_0FFF;
    endfunction
    function automatic logic [31:0] vpg(input int i);
        return 32'h0010_0000 + 32'(i) * 32'h1000;
    endfunction
    function automatic logic [31:0] ppg(input int i);
        return 32'h4000_0000 + 32'(i) * 32'h0002_0000;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(lu_hit == 1'b0, "R1 reset hit", 64'(lu_hit), 64'd0);
        chk(lu_pa == 32'd0, "R1 reset pa", 64'(lu_pa), 64'd0);
        expect_miss(32'h0000_0000, "R1 empty lookup");
        expect_miss(vpg(0), "R1 empty lookup");

        // R2 R3 R4: sweep of every size code over page edges
        for (int s = 0; s < 4; s++) begin
            logic [31:0] m, vb, pb;
            logic [5:0] at;
            m  = smask(s);
            vb = 32'h1234_5678 & ~m;
            pb = 32'h0ABC_DEF0 & ~m;
            at = 6'(s * 9 + 5);
            flush_all();
            fill(32'h1234_5678, 32'h0ABC_DEF0, 2'(s), at);
            expect_miss(vb - 32'd1, "R2 below base");
            expect_hit(vb, 1'b0, pb, at, "R4 aligned base");
            expect_hit(vb + m, 1'b0, pb | m, at, "R2 last byte");
            expect_miss(vb + m + 32'd1, "R2 past end");
            expect_hit(vb + (32'h0001_3579 & m), 1'b0, pb | (32'h0001_3579 & m), at, "R3 offset");
            expect_hit(vb + (m >> 1), 1'b0, pb | (m >> 1), at, "R3 mid");
        end

        // R2: page ending at the top of the address space
        flush_all();
        fill(32'hFFC0_0000, 32'h0080_0000, 2'd2, 6'h01);
        expect_hit(32'hFFFF_FFFF, 1'b0, 32'h00BF_FFFF, 6'h01, "R2 top of space");
        expect_miss(32'hFFBF_FFFF, "R2 below top page");

        // R5 R6 R7: eviction order
        flush_all();
        for (int i = 0; i < 4; i++) fill(vpg(i), ppg(i), 2'd0, 6'h00);
        for (int i = 0; i < 4; i++) expect_hit(vpg(i) + 32'h234, 1'b0, ppg(i) | 32'h234, 6'h00, "R5 fill");
        fill(vpg(4), ppg(4), 2'd0, 6'h00);
        expect_miss(vpg(0), "R5 LRU evicted");
        for (int i = 1; i < 5; i++) expect_hit(vpg(i), 1'b0, ppg(i), 6'h00, "R6 resident");
        expect_hit(vpg(1), 1'b1, ppg(1), 6'h00, "R7 promote");
        fill(vpg(5), ppg(5), 2'd0, 6'h00);
        expect_miss(vpg(2), "R7 promoted page spared");
        expect_hit(vpg(1), 1'b0, ppg(1), 6'h00, "R7 promoted page kept");
        expect_hit(vpg(3), 1'b0, ppg(3), 6'h00, "R7 no-promote hit");
        fill(vpg(6), ppg(6), 2'd0, 6'h00);
        expect_miss(vpg(3), "R7 order unchanged without promote");
        expect_hit(vpg(4), 1'b0, ppg(4), 6'h00, "R7 next oldest kept");

        // R8: overlapping pages, most recent wins
        flush_all();
        fill(32'h0040_0000, 32'h1000_0000, 2'd2, 6'h02);
        fill(32'h0040_1000, 32'h2000_0000, 2'd0, 6'h04);
        expect_hit(32'h0040_1234, 1'b0, 32'h2000_0234, 6'h04, "R8 newer small page");
        expect_hit(32'h0040_2000, 1'b1, 32'h1000_2000, 6'h02, "R8 only large page");
        expect_hit(32'h0040_1234, 1'b0, 32'h1000_1234, 6'h02, "R8 promoted large wins");

        // R9
        flush_all();
        expect_miss(32'h0040_1234, "R9 flushed");
        expect_miss(32'h0040_2000, "R9 flushed");

        // R10: selective invalidate
        fill(vpg(0), ppg(0), 2'd0, 6'h10);
        fill(vpg(1), ppg(1), 2'd0, 6'h00);
        fill(vpg(2), ppg(2), 2'd0, 6'h11);
        fill(vpg(3), ppg(3), 2'd0, 6'h0F);
        inv_nonglobal = 1'b1;
        tick();
        expect_miss(vpg(1), "R10 non-global freed");
        expect_miss(vpg(3), "R10 non-global freed");
        expect_hit(vpg(0), 1'b0, ppg(0), 6'h10, "R10 global kept");
        expect_hit(vpg(2), 1'b0, ppg(2), 6'h11, "R10 global kept");
        fill(vpg(4), ppg(4), 2'd0, 6'h00);
        fill(vpg(5), ppg(5), 2'd0, 6'h00);
        expect_hit(vpg(0), 1'b0, ppg(0), 6'h10, "R5 free pool used first");
        expect_hit(vpg(2), 1'b0, ppg(2), 6'h11, "R5 free pool used first");
        fill(vpg(6), ppg(6), 2'd0, 6'h00);
        expect_miss(vpg(0), "R10 older global evicted first");
        expect_hit(vpg(2), 1'b0, ppg(2), 6'h11, "R10 newer global kept");

        // R11: invalidate and fill together
        inv_all = 1'b1;
        set_fill(vpg(7), ppg(7), 2'd0, 6'h00);
        tick();
        expect_hit(vpg(7), 1'b0, ppg(7), 6'h00, "R11 fill survives flush-all");
        expect_miss(vpg(6), "R11 old page gone");
        inv_nonglobal = 1'b1;
        set_fill(vpg(8), ppg(8), 2'd0, 6'h00);
        tick();
        expect_hit(vpg(8), 1'b0, ppg(8), 6'h00, "R11 fill survives selective flush");
        expect_miss(vpg(7), "R11 non-global gone");

        // R12: lookup concurrent with invalidate and with fill
        lu_req = 1'b1; lu_va = vpg(8); inv_all = 1'b1;
        tick();
        chk(lu_hit == 1'b1, "R12 pre-flush view", 64'(lu_hit), 64'd1);
        chk(lu_pa == ppg(8), "R12 pre-flush view", 64'(lu_pa), 64'(ppg(8)));
        expect_miss(vpg(8), "R12 flushed afterwards");
        for (int i = 0; i < 4; i++) fill(vpg(i), ppg(i), 2'd0, 6'h00);
        lu_req = 1'b1; lu_va = vpg(0); lu_promote = 1'b1;
        set_fill(vpg(4), ppg(4), 2'd0, 6'h00);
        tick();
        chk(lu_hit == 1'b1, "R12 lookup during fill", 64'(lu_hit), 64'd1);
        expect_miss(vpg(0), "R12 promotion dropped");
        expect_hit(vpg(1), 1'b0, ppg(1), 6'h00, "R12 neighbour kept");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule